// File: doc/BRIEF.md
# Time-Triggered Table Dispatcher

This block schedules tasks in hardware from a static table. A round timer counts time ticks through a dispatcher round whose length is always a whole number of bus rounds. Each table entry names a task, the round time at which it may start and the most ticks it may run. The dispatcher walks the table in order. When the next entry's start time has come and no table task holds the processor, it starts that task with a one-cycle activate strobe. At the same moment it loads a countdown alarm with the entry's runtime limit.

A task leaves in one of two ways. If it reports completion, control returns to the idle task. If the alarm runs out first, the task is preempted, a deadline interrupt fires with the offending task's ID, and the idle task takes over. The idle task has no entry of its own and fills all time no table task uses.

Software writes entries and the entry count into a shadow table. The shadow table becomes active only at the next round wrap. The table index restarts at the same wrap.

Top module: `ttd_dispatcher`

## Requirements
- R1: After synchronous reset, `cur_idle` is 1, `cur_task` equals `IDLE_ID`, and `activate`, `overlap_err`, `deadline_irq`, `round_start` and `viol_task` are 0. The active table is empty (count 0).
- R2: Round time advances by one on each cycle with `tick` high, counting 0 to ROUND_LEN-1, where ROUND_LEN = BUS_TICKS*ROUND_MULT. The tick taken at ROUND_LEN-1 wraps the time to 0. `round_start` is high for exactly the one cycle after that edge, so two pulses are always ROUND_LEN ticks apart.
- R3: Entry writes (`tbl_we` at `tbl_addr`) and count writes (`cnt_we`) land in a shadow table. The active table takes the shadow contents at the wrap edge, so a write has no effect on dispatch before the next `round_start`. A count above 16 is stored as 16.
- R4: While idle and not on a wrap edge, the entry at the current index is due when the index is below the active count and its start time is at most the round time. One cycle after the edge on which it becomes due, `activate` is high for one cycle, `cur_idle` is 0, `cur_task` shows the entry ID, and the index advances.
- R5: Entries at or beyond the active count never start. An entry whose start time is ROUND_LEN or more never starts, and it also blocks every entry after it in the same round.
- R6: `task_done` while a table task runs makes `cur_idle` 1 and `cur_task` equal `IDLE_ID` on the following cycle. `task_done` while idle has no effect.
- R7: The alarm is loaded with the entry's runtime; a runtime of 0 counts as 1. Each later tick while the task runs uses one unit. On the tick that uses the last unit without `task_done`, the next cycle shows a one-cycle `deadline_irq`, shows `viol_task` holding that task ID until the next violation, and shows the task idle. `task_done` in the same cycle takes precedence.
- R8: A task started when the round time is already past its start time pulses `overlap_err` together with its `activate`.
- R9: At a wrap the index returns to entry 0. A task still running carries on across the wrap, and entry 0 then starts late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick, one round-time unit |
| task_done | input | 1 | Completion strobe from the running task |
| tbl_we | input | 1 | Shadow entry write enable |
| tbl_addr | input | 4 | Shadow entry index |
| tbl_id | input | 4 | Task ID to write |
| tbl_start | input | 8 | Start time to write |
| tbl_runtime | input | 8 | Runtime limit to write, in ticks |
| cnt_we | input | 1 | Shadow entry-count write enable |
| cnt_val | input | 5 | Entry count to write |
| cur_task | output | 4 | Running task ID, `IDLE_ID` when idle |
| cur_idle | output | 1 | High while the idle task holds the processor |
| activate | output | 1 | One-cycle task start strobe |
| overlap_err | output | 1 | Late-start pulse, coincident with `activate` |
| deadline_irq | output | 1 | One-cycle deadline-violation interrupt |
| viol_task | output | 4 | ID of the last task that overran |
| round_start | output | 1 | One-cycle pulse at the start of each round |

## Verification
A wrong table index or a stale active table shows up at the next due start time. `cur_task` and `activate` then disagree with the expected entry within one cycle of the start edge. A wrong alarm count moves `deadline_irq` off the expected tick, or drops it entirely. A wrong round counter shifts `round_start` and every later activation by at least one tick. A cycle-exact reference model in the bench compares every output on every cycle, so each of these errors is reported in the cycle it first appears.

// File: rtl/ttd_pkg.sv
package ttd_pkg;
    localparam int ENTRIES = 16;
    localparam int ID_W    = 4;
    localparam int START_W = 8;
    localparam int RUN_W   = 8;
    localparam int ADDR_W  = $clog2(ENTRIES);
    localparam int IDX_W   = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ID_W-1:0]    id;
        logic [START_W-1:0] start;
        logic [RUN_W-1:0]   runtime;
    } slot_t;

    typedef enum logic {
        OCC_IDLE = 1'b0,
        OCC_TASK = 1'b1
    } occ_e;

    function automatic logic [RUN_W-1:0] alarm_seed(input logic [RUN_W-1:0] rt);
        return (rt == '0) ? RUN_W'(1) : rt;
    endfunction

    function automatic logic [IDX_W-1:0] clamp_count(input logic [IDX_W-1:0] c);
        return (c > IDX_W'(ENTRIES)) ? IDX_W'(ENTRIES) : c;
    endfunction
endpackage

// File: rtl/ttd_table.sv
module ttd_table
    import ttd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  slot_t             wr_slot,
    input  logic              cnt_we,
    input  logic [IDX_W-1:0]  cnt_val,
    input  logic              swap,
    input  logic [IDX_W-1:0]  rd_idx,
    output slot_t             rd_slot,
    output logic [IDX_W-1:0]  act_cnt
);
    slot_t            shadow_q [ENTRIES];
    slot_t            active_q [ENTRIES];
    logic [IDX_W-1:0] shadow_cnt_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= '0;
                active_q[g] <= '0;
            end else begin
                if (swap)
                    active_q[g] <= shadow_q[g];
                if (wr_en && wr_addr == ADDR_W'(g))
                    shadow_q[g] <= wr_slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_cnt_q <= '0;
            act_cnt      <= '0;
        end else begin
            if (swap)
                act_cnt <= shadow_cnt_q;
            if (cnt_we)
                shadow_cnt_q <= clamp_count(cnt_val);
        end
    end

    always_comb begin
        rd_slot = '0;
        if (rd_idx < IDX_W'(ENTRIES))
            rd_slot = active_q[rd_idx[ADDR_W-1:0]];
    end

    assert_active_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(act_cnt));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        act_cnt <= IDX_W'(ENTRIES));
endmodule

// File: rtl/ttd_round.sv
module ttd_round #(
    parameter int ROUND_LEN = 32,
    localparam int RT_W     = (ROUND_LEN > 1) ? $clog2(ROUND_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    output logic [RT_W-1:0] rtime,
    output logic            wrap,
    output logic            round_start
);
    localparam logic [RT_W-1:0] LAST = RT_W'(ROUND_LEN - 1);

    assign wrap = tick && (rtime == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            rtime       <= '0;
            round_start <= 1'b0;
        end else begin
            round_start <= wrap;
            if (wrap)
                rtime <= '0;
            else if (tick)
                rtime <= rtime + RT_W'(1);
        end
    end

    // Tick counter since the last pulse, used only by the spacing check.
    logic [RT_W:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (round_start) begin
                since_q <= {1'b0, tick};
                seen_q  <= 1'b1;
            end else if (tick) begin
                since_q <= since_q + (RT_W+1)'(1);
            end
        end
    end

    assert_round_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (round_start && seen_q) |-> since_q == (RT_W+1)'(ROUND_LEN));
    assert_round_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        round_start |-> rtime == '0 || $past(tick) == 1'b1);
endmodule

// File: rtl/ttd_alarm.sv
module ttd_alarm
    import ttd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RUN_W-1:0] seed,
    input  logic             armed,
    input  logic             tick,
    output logic             expire
);
    logic [RUN_W-1:0] cnt_q;

    assign expire = armed && tick && (cnt_q == RUN_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= seed;
        else if (armed && tick && cnt_q > RUN_W'(1))
            cnt_q <= cnt_q - RUN_W'(1);
    end

    assert_alarm_live_R7: assert property (@(posedge clk) disable iff (rst)
        armed |-> cnt_q != '0);
endmodule

// File: rtl/ttd_dispatcher.sv
module ttd_dispatcher
    import ttd_pkg::*;
#(
    parameter int              BUS_TICKS  = 8,
    parameter int              ROUND_MULT = 4,
    parameter logic [ID_W-1:0] IDLE_ID    = 4'hF,
    localparam int ROUND_LEN = BUS_TICKS * ROUND_MULT,
    localparam int RT_W      = (ROUND_LEN > 1) ? $clog2(ROUND_LEN) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               task_done,
    input  logic               tbl_we,
    input  logic [ADDR_W-1:0]  tbl_addr,
    input  logic [ID_W-1:0]    tbl_id,
    input  logic [START_W-1:0] tbl_start,
    input  logic [RUN_W-1:0]   tbl_runtime,
    input  logic               cnt_we,
    input  logic [IDX_W-1:0]   cnt_val,
    output logic [ID_W-1:0]    cur_task,
    output logic               cur_idle,
    output logic               activate,
    output logic               overlap_err,
    output logic               deadline_irq,
    output logic [ID_W-1:0]    viol_task,
    output logic               round_start
);
    logic [RT_W-1:0]  rtime;
    logic             wrap;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] act_cnt;
    slot_t            cur_slot;
    slot_t            wr_slot;
    occ_e             occ_q;
    logic [ID_W-1:0]  run_id_q;
    logic             expire;
    logic             due;
    logic             late;
    logic             start_task;

    assign wr_slot = '{id: tbl_id, start: tbl_start, runtime: tbl_runtime};

    ttd_round #(.ROUND_LEN(ROUND_LEN)) u_round (
        .clk(clk), .rst(rst), .tick(tick),
        .rtime(rtime), .wrap(wrap), .round_start(round_start)
    );

    ttd_table u_table (
        .clk(clk), .rst(rst),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_slot(wr_slot),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .swap(wrap), .rd_idx(idx_q),
        .rd_slot(cur_slot), .act_cnt(act_cnt)
    );

    assign due = (occ_q == OCC_IDLE) && !wrap && (idx_q < act_cnt)
                 && (32'(cur_slot.start) <= 32'(rtime));
    assign late       = 32'(cur_slot.start) < 32'(rtime);
    assign start_task = due;

    ttd_alarm u_alarm (
        .clk(clk), .rst(rst),
        .load(start_task), .seed(alarm_seed(cur_slot.runtime)),
        .armed(occ_q == OCC_TASK), .tick(tick), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q        <= OCC_IDLE;
            idx_q        <= '0;
            run_id_q     <= '0;
            activate     <= 1'b0;
            overlap_err  <= 1'b0;
            deadline_irq <= 1'b0;
            viol_task    <= '0;
        end else begin
            activate     <= 1'b0;
            overlap_err  <= 1'b0;
            deadline_irq <= 1'b0;
            if (occ_q == OCC_TASK) begin
                if (task_done) begin
                    occ_q <= OCC_IDLE;
                end else if (expire) begin
                    occ_q        <= OCC_IDLE;
                    deadline_irq <= 1'b1;
                    viol_task    <= run_id_q;
                end
            end else if (start_task) begin
                occ_q       <= OCC_TASK;
                run_id_q    <= cur_slot.id;
                activate    <= 1'b1;
                overlap_err <= late;
                idx_q       <= idx_q + IDX_W'(1);
            end
            if (wrap)
                idx_q <= '0;
        end
    end

    assign cur_idle = (occ_q == OCC_IDLE);
    assign cur_task = cur_idle ? IDLE_ID : run_id_q;

    assert_act_single_R4: assert property (@(posedge clk) disable iff (rst)
        activate |=> !activate);
    assert_act_busy_R4: assert property (@(posedge clk) disable iff (rst)
        activate |-> !cur_idle);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!cur_idle && task_done) |=> cur_idle);
    assert_irq_idle_R7: assert property (@(posedge clk) disable iff (rst)
        deadline_irq |-> (cur_idle && !activate));
    assert_overlap_act_R8: assert property (@(posedge clk) disable iff (rst)
        overlap_err |-> activate);
    assert_idx_reset_R9: assert property (@(posedge clk) disable iff (rst)
        round_start |-> idx_q <= IDX_W'(1));
endmodule

// File: tb/ttd_dispatcher_test.sv
module ttd_dispatcher_test;
    localparam int CLK_PERIOD = 10;
    localparam int RL = 32;
    localparam logic [3:0] IDLE = 4'hF;

    logic clk = 0, rst = 1, tick = 0, task_done = 0;
    logic tbl_we = 0, cnt_we = 0;
    logic [3:0] tbl_addr = 0, tbl_id = 0;
    logic [7:0] tbl_start = 0, tbl_runtime = 0;
    logic [4:0] cnt_val = 0;
    logic [3:0] cur_task, viol_task;
    logic cur_idle, activate, overlap_err, deadline_irq, round_start;

    int checks = 0, errors = 0, cyc = 0;
    bit auto_done = 0, rand_mode = 0;

    ttd_dispatcher uut (
        .clk(clk), .rst(rst), .tick(tick), .task_done(task_done),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_id(tbl_id),
        .tbl_start(tbl_start), .tbl_runtime(tbl_runtime),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .cur_task(cur_task), .cur_idle(cur_idle), .activate(activate),
        .overlap_err(overlap_err), .deadline_irq(deadline_irq),
        .viol_task(viol_task), .round_start(round_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    int m_rt, m_idx, m_alarm, m_acnt, m_scnt;
    bit m_run;
    logic [3:0] m_id;
    int s_id[16], s_st[16], s_rn[16], a_id[16], a_st[16], a_rn[16];
    bit e_act, e_ovl, e_irq, e_rs;
    logic [3:0] e_viol;

    function automatic int clampc(input int c);
        return (c > 16) ? 16 : c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rt = 0; m_idx = 0; m_alarm = 0; m_acnt = 0; m_scnt = 0; m_run = 0; m_id = 0;
            e_act = 0; e_ovl = 0; e_irq = 0; e_rs = 0; e_viol = 0;
            for (int i = 0; i < 16; i++) begin
                s_id[i] = 0; s_st[i] = 0; s_rn[i] = 0; a_id[i] = 0; a_st[i] = 0; a_rn[i] = 0;
            end
        end else begin
            bit wrap, due;
            wrap = tick && (m_rt == RL - 1);
            due  = !m_run && !wrap && (m_idx < m_acnt) && (a_st[m_idx] <= m_rt);
            e_act = 0; e_ovl = 0; e_irq = 0;
            if (m_run) begin
                if (task_done) m_run = 0;
                else if (tick && m_alarm == 1) begin
                    m_run = 0; e_irq = 1; e_viol = m_id;
                end else if (tick) m_alarm = m_alarm - 1;
            end else if (due) begin
                m_run = 1; m_id = 4'(a_id[m_idx]); e_act = 1;
                e_ovl = (a_st[m_idx] < m_rt);
                m_alarm = (a_rn[m_idx] == 0) ? 1 : a_rn[m_idx];
                m_idx = m_idx + 1;
            end
            e_rs = wrap;
            if (wrap) begin
                m_idx = 0; m_acnt = m_scnt;
                for (int i = 0; i < 16; i++) begin
                    a_id[i] = s_id[i]; a_st[i] = s_st[i]; a_rn[i] = s_rn[i];
                end
            end
            if (tbl_we) begin
                s_id[tbl_addr] = tbl_id; s_st[tbl_addr] = tbl_start; s_rn[tbl_addr] = tbl_runtime;
            end
            if (cnt_we) m_scnt = clampc(cnt_val);
            if (wrap) m_rt = 0; else if (tick) m_rt = m_rt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Event records for directed checks.
    int acts_before_rs = 0, rs_seen = 0, first_after_rs = -1;
    bit saw9 = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            chk(activate == e_act, "R4 activate", activate, e_act);
            chk(cur_task == (m_run ? m_id : IDLE), "R6 cur_task", cur_task, m_run ? m_id : IDLE);
            chk(cur_idle == !m_run, "R6 cur_idle", cur_idle, !m_run);
            chk(overlap_err == e_ovl, "R8 overlap_err", overlap_err, e_ovl);
            chk(deadline_irq == e_irq, "R7 deadline_irq", deadline_irq, e_irq);
            chk(viol_task == e_viol, "R7 viol_task", viol_task, e_viol);
            chk(round_start == e_rs, "R2 round_start", round_start, e_rs);
            if (!rand_mode) begin
                if (round_start) rs_seen++;
                if (activate && rs_seen == 0) acts_before_rs++;
                if (activate && rs_seen == 2 && first_after_rs < 0) first_after_rs = cur_task;
                if (cur_task == 4'd9) saw9 = 1;
            end
            task_done = auto_done && (cur_task == 4'd3);
            if (rand_mode) begin
                tick      = ($urandom_range(0, 3) != 0);
                task_done = ($urandom_range(0, 7) == 0);
                tbl_we    = ($urandom_range(0, 15) == 0);
                tbl_addr  = 4'($urandom_range(0, 15));
                tbl_id    = 4'($urandom_range(0, 14));
                tbl_start = 8'($urandom_range(0, 36));
                tbl_runtime = 8'($urandom_range(0, 9));
                cnt_we    = ($urandom_range(0, 63) == 0);
                cnt_val   = 5'($urandom_range(0, 20));
            end
        end
    end

    task automatic wr_entry(input int a, input int id, input int st, input int rn);
        @(negedge clk);
        tbl_we = 1; tbl_addr = 4'(a); tbl_id = 4'(id); tbl_start = 8'(st); tbl_runtime = 8'(rn);
        @(negedge clk);
        tbl_we = 0;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk(cur_idle == 1 && cur_task == IDLE, "R1 idle after reset", cur_task, IDLE);
        chk(!activate && !overlap_err && !deadline_irq && !round_start && viol_task == 0,
            "R1 outputs low after reset", {activate, overlap_err, deadline_irq, round_start}, 0);
        // Directed table: early finish, overrun, late start, out-of-round entry.
        wr_entry(0, 3, 2, 4);
        wr_entry(1, 5, 10, 3);
        wr_entry(2, 7, 12, 5);
        wr_entry(3, 9, 40, 2);
        @(negedge clk); cnt_we = 1; cnt_val = 5'd4;
        @(negedge clk); cnt_we = 0;
        auto_done = 1; tick = 1;
        repeat (3 * RL + 10) @(negedge clk);
        chk(acts_before_rs == 0, "R3 no dispatch before first round wrap", acts_before_rs, 0);
        chk(rs_seen >= 3, "R2 round pulses seen", rs_seen, 3);
        chk(first_after_rs == 3, "R9 index restarts at entry 0", first_after_rs, 3);
        chk(!saw9, "R5 out-of-round entry never runs", saw9, 0);
        // Runtime-0 entry and count clamp.
        wr_entry(0, 2, 1, 0);
        @(negedge clk); cnt_we = 1; cnt_val = 5'd20;
        @(negedge clk); cnt_we = 0;
        repeat (2 * RL + 5) @(negedge clk);
        // Randomised phase.
        auto_done = 0; rand_mode = 1;
        repeat (4000) @(negedge clk);
        rand_mode = 0; tick = 0; task_done = 0; tbl_we = 0; cnt_we = 0;
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule